// File: doc/BRIEF.md
# Accumulator ALU with Packed-Decimal Arithmetic

This block is the arithmetic and logic datapath for an 8-bit accumulator processor. Each cycle it takes an accumulator value, a second operand, a four-bit operation code and the incoming processor status byte. On the next rising clock edge it presents the operation result and the updated status byte. The surrounding core routes the X or Y register onto the accumulator input for register compares, and stores the result wherever the instruction requires. The block never reads or writes memory.

Add and subtract work in binary or packed BCD, as the decimal flag of the incoming status byte selects. Decimal operations turn each operand into a binary value from 0 to 165, do the arithmetic, then split the outcome back into two decimal digits. The `enh` input selects the enhanced processor variant. Under that variant a decimal add or subtract also refreshes the negative and zero flags. Otherwise those two flags pass through from the incoming status.

Top module: `bcd_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `res` becomes 0x00 and `st_out` becomes 0x20 on that edge.
- R2: The outputs change only at a rising edge and reflect the inputs present at that edge. There is one register stage.
- R3: Binary add (op 0, decimal flag bit 3 clear): `res` = acc + opnd + C, with C in bit 0. C out is set when the 9-bit sum is above 0xFF. V (bit 6) is set when both operands share a sign bit and the result sign differs from it. N (bit 7) and Z (bit 1) follow the result.
- R4: Binary subtract (op 1, bit 3 clear): `res` = acc - opnd - (1 - C). C out means no borrow. V is set when the operand signs differ and the result sign differs from acc. N and Z follow the result.
- R5: Decimal add (op 1 is subtract, op 0 is add, bit 3 set): both bytes are read as two-digit BCD (high digit times ten plus low digit) and added with C. C out is set when the total exceeds 99. `res` holds the tens and units digits of the total.
- R6: Decimal subtract (op 1, bit 3 set): binary value of acc minus that of opnd minus (1 - C). On a borrow, 100 is added before conversion back to BCD. C out means no borrow.
- R7: In decimal add and subtract, V passes through. N and Z follow the result only when `enh` is 1. When `enh` is 0 they pass through from `st_in`.
- R8: Compare (op 5): C is set when acc >= opnd (unsigned). N and Z come from the 8-bit difference. V passes through, and `res` equals acc.
- R9: AND (op 2), OR (op 3), XOR (op 4) of acc with opnd, and load (op 14, `res` = opnd): N comes from bit 7 and Z from a zero result. C and V pass through.
- R10: Shifts act on opnd: ASL (op 6) and ROL (op 8) shift left with C taken from bit 7, and ROL fills bit 0 from C. LSR (op 7) and ROR (op 9) shift right with C taken from bit 0, and ROR fills bit 7 from C. N and Z follow the result, and LSR always clears N.
- R11: Bit test (op 10): Z is set when acc AND opnd is zero, N and V copy opnd bits 7 and 6, and `res` equals acc. The immediate form (op 11) changes only Z.
- R12: Test-and-set (op 12) gives `res` = opnd OR acc, and test-and-reset (op 13) gives `res` = opnd AND NOT acc. Both set Z when acc AND opnd is zero and change no other flag.
- R13: Bits 4, 3 and 2 of `st_out` copy `st_in`, and bit 5 always reads 1. Op 15 returns acc with every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator, or the register being compared |
| opnd | input | 8 | Second operand, or the value being shifted |
| st_in | input | 8 | Incoming status byte (N V 1 B D I Z C, bit 7 down to bit 0) |
| enh | input | 1 | Enhanced-variant select |
| res | output | 8 | Registered result |
| st_out | output | 8 | Registered updated status byte |

## Verification
The hardest case to reach is a decimal subtract that borrows, because only that path adds 100 before the digits are split. It must also be seen with `enh` both set and clear, while the incoming N, Z and V hold values that a pass-through can tell apart from a recomputed flag. The stimulus table sets N or V in `st_in` on the decimal rows, so a wrongly recomputed or wrongly held flag shows up at `st_out`. A borrow row (10 minus 25) exercises the +100 adjustment, and a 99 + 1 row exercises the decimal carry and wrap to zero.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int W = 8;

  localparam int FN = 7;
  localparam int FV = 6;
  localparam int FR = 5;
  localparam int FD = 3;
  localparam int FZ = 1;
  localparam int FC = 0;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_AND  = 4'd2,  OP_OR   = 4'd3,
    OP_XOR  = 4'd4,  OP_CMP  = 4'd5,  OP_SHL  = 4'd6,  OP_SHR  = 4'd7,
    OP_RTL  = 4'd8,  OP_RTR  = 4'd9,  OP_TST  = 4'd10, OP_TSTI = 4'd11,
    OP_SETB = 4'd12, OP_CLRB = 4'd13, OP_LOAD = 4'd14, OP_PASS = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic [W-1:0] res;
    logic         n, v, z, c;
    logic         wn, wv, wz, wc;
  } alu_out_t;
endpackage

// File: rtl/bcd_alu_arith.sv
module bcd_alu_arith
  import bcd_alu_pkg::*;
(
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         cin,
  input  logic         dec,
  input  logic         enh,
  output alu_out_t     o
);
  localparam int WL = 2 * W;

  function automatic logic [W-1:0] to_bin(input logic [W-1:0] x);
    return {4'd0, x[7:4]} * 8'd10 + {4'd0, x[3:0]};
  endfunction

  function automatic logic [W-1:0] to_bcd(input logic [WL-1:0] x);
    logic [WL-1:0] tens, ones;
    tens = (x / 16'd10) % 16'd10;
    ones = x % 16'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  logic [W:0]    bsum, bdif, cdif;
  logic [W-1:0]  ba, bm;
  logic [W:0]    dsum;
  logic [WL-1:0] ddif, dadj;
  logic          dborrow;

  always_comb begin
    bsum = {1'b0, a} + {1'b0, m} + {{W{1'b0}}, cin};
    bdif = {1'b0, a} - {1'b0, m} - {{W{1'b0}}, ~cin};
    cdif = {1'b0, a} - {1'b0, m};
    ba   = to_bin(a);
    bm   = to_bin(m);
    dsum = {1'b0, ba} + {1'b0, bm} + {{W{1'b0}}, cin};
    ddif = {{W{1'b0}}, ba} - {{W{1'b0}}, bm} - {{(WL-1){1'b0}}, ~cin};
    dborrow = ddif[WL-1];
    dadj = dborrow ? ddif + 16'd100 : ddif;

    o = '0;
    o.wc = 1'b1;
    o.wn = 1'b1;
    o.wz = 1'b1;
    unique case (op)
      OP_ADD: begin
        if (dec) begin
          o.res = to_bcd({{(W-1){1'b0}}, dsum});
          o.c   = (dsum > 9'd99);
          o.wn  = enh;
          o.wz  = enh;
        end else begin
          o.res = bsum[W-1:0];
          o.c   = bsum[W];
          o.v   = (a[7] == m[7]) && (a[7] != bsum[7]);
          o.wv  = 1'b1;
        end
      end
      OP_SUB: begin
        if (dec) begin
          o.res = to_bcd(dadj);
          o.c   = ~dborrow;
          o.wn  = enh;
          o.wz  = enh;
        end else begin
          o.res = bdif[W-1:0];
          o.c   = ~bdif[W];
          o.v   = (a[7] != m[7]) && (a[7] != bdif[7]);
          o.wv  = 1'b1;
        end
      end
      default: begin
        o.res = a;
        o.c   = ~cdif[W];
      end
    endcase
    o.n = (op == OP_CMP) ? cdif[7] : o.res[7];
    o.z = (op == OP_CMP) ? (cdif[W-1:0] == '0) : (o.res == '0);
  end
endmodule

// File: rtl/bcd_alu_logic.sv
module bcd_alu_logic
  import bcd_alu_pkg::*;
(
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         cin,
  output alu_out_t     o
);
  logic [W-1:0] am;

  always_comb begin
    am = a & m;
    o  = '0;
    o.wn = 1'b1;
    o.wz = 1'b1;
    unique case (op)
      OP_AND:  o.res = am;
      OP_OR:   o.res = a | m;
      OP_XOR:  o.res = a ^ m;
      OP_LOAD: o.res = m;
      OP_SHL:  begin o.res = {m[W-2:0], 1'b0}; o.c = m[W-1]; o.wc = 1'b1; end
      OP_RTL:  begin o.res = {m[W-2:0], cin};  o.c = m[W-1]; o.wc = 1'b1; end
      OP_SHR:  begin o.res = {1'b0, m[W-1:1]}; o.c = m[0];   o.wc = 1'b1; end
      OP_RTR:  begin o.res = {cin, m[W-1:1]};  o.c = m[0];   o.wc = 1'b1; end
      OP_TST:  begin o.res = a; o.wv = 1'b1; end
      OP_TSTI: begin o.res = a; o.wn = 1'b0; end
      OP_SETB: begin o.res = m | a;  o.wn = 1'b0; end
      OP_CLRB: begin o.res = m & ~a; o.wn = 1'b0; end
      default: begin o.res = a; o.wn = 1'b0; o.wz = 1'b0; end
    endcase
    if (op == OP_TST) begin
      o.n = m[7];
      o.v = m[6];
    end else begin
      o.n = o.res[7];
    end
    if (op inside {OP_TST, OP_TSTI, OP_SETB, OP_CLRB})
      o.z = (am == '0);
    else
      o.z = (o.res == '0);
  end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] st_in,
  input  logic         enh,
  output logic [W-1:0] res,
  output logic [W-1:0] st_out
);
  localparam logic [W-1:0] ST_RESET = 8'h20;

  alu_op_e  op_e;
  alu_out_t ar_o, lg_o, sel;
  logic     is_arith;
  logic [W-1:0] st_nxt;

  assign op_e     = alu_op_e'(op);
  assign is_arith = (op_e == OP_ADD) || (op_e == OP_SUB) || (op_e == OP_CMP);

  bcd_alu_arith u_arith (
    .op(op_e), .a(acc), .m(opnd), .cin(st_in[FC]),
    .dec(st_in[FD]), .enh(enh), .o(ar_o)
  );

  bcd_alu_logic u_logic (
    .op(op_e), .a(acc), .m(opnd), .cin(st_in[FC]), .o(lg_o)
  );

  always_comb begin
    sel        = is_arith ? ar_o : lg_o;
    st_nxt     = st_in;
    st_nxt[FR] = 1'b1;
    st_nxt[FN] = sel.wn ? sel.n : st_in[FN];
    st_nxt[FV] = sel.wv ? sel.v : st_in[FV];
    st_nxt[FZ] = sel.wz ? sel.z : st_in[FZ];
    st_nxt[FC] = sel.wc ? sel.c : st_in[FC];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res    <= '0;
      st_out <= ST_RESET;
    end else begin
      res    <= sel.res;
      st_out <= st_nxt;
    end
  end
endmodule

// File: rtl/bcd_alu_chk.sv
module bcd_alu_chk
  import bcd_alu_pkg::*;
(
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op,
  input logic [W-1:0] acc,
  input logic [W-1:0] opnd,
  input logic [W-1:0] st_in,
  input logic         enh,
  input logic [W-1:0] res,
  input logic [W-1:0] st_out
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (res == 8'h00 && st_out == 8'h20)); // R1
  AST_CTRL_PASS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (st_out[4:2] == $past(st_in[4:2]) && st_out[FR])); // R13
  AST_LOGIC_KEEP_CV: assert property (@(posedge clk) disable iff (rst)
    (!rst && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_LOAD))
    |=> (st_out[FC] == $past(st_in[FC]) && st_out[FV] == $past(st_in[FV]))); // R9
  AST_SHR_CLEARS_N: assert property (@(posedge clk) disable iff (rst)
    (!rst && op == OP_SHR) |=> !st_out[FN]); // R10
  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (!rst && op == OP_CMP) |=> (res == $past(acc) && st_out[FV] == $past(st_in[FV]))); // R8
  AST_DEC_KEEPS_V: assert property (@(posedge clk) disable iff (rst)
    (!rst && (op == OP_ADD || op == OP_SUB) && st_in[FD]) |=> st_out[FV] == $past(st_in[FV])); // R7
  AST_DEC_ENH_Z: assert property (@(posedge clk) disable iff (rst)
    (!rst && (op == OP_ADD || op == OP_SUB) && st_in[FD] && enh) |=> st_out[FZ] == (res == 8'h00)); // R7
  AST_TST_COPIES_NV: assert property (@(posedge clk) disable iff (rst)
    (!rst && op == OP_TST) |=> (st_out[7:6] == $past(opnd[7:6]) && res == $past(acc))); // R11
endmodule

bind bcd_alu bcd_alu_chk u_chk (.*);

// File: tb/bcd_alu_tb.sv
module bcd_alu_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op = 4'd15;
  logic [7:0] acc = 8'h00, opnd = 8'h00, st_in = 8'h20;
  logic       enh = 1'b0;
  logic [7:0] res, st_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_alu u_dut (
    .clk(clk), .rst(rst), .op(op), .acc(acc), .opnd(opnd),
    .st_in(st_in), .enh(enh), .res(res), .st_out(st_out)
  );

  // {op, acc, opnd, st_in, enh, req, exp_res, exp_st}
  localparam int NV = 29;
  localparam logic [48:0] VEC [NV] = '{
    {4'd0,  8'h50, 8'h50, 8'h20, 1'b0, 4'd3,  8'hA0, 8'hE0},
    {4'd0,  8'hFF, 8'h01, 8'h21, 1'b0, 4'd3,  8'h01, 8'h21},
    {4'd0,  8'h80, 8'h80, 8'h20, 1'b0, 4'd3,  8'h00, 8'h63},
    {4'd1,  8'h50, 8'h10, 8'h21, 1'b0, 4'd4,  8'h40, 8'h21},
    {4'd1,  8'h00, 8'h01, 8'h21, 1'b0, 4'd4,  8'hFF, 8'hA0},
    {4'd1,  8'h80, 8'h01, 8'h21, 1'b0, 4'd4,  8'h7F, 8'h61},
    {4'd1,  8'h05, 8'h05, 8'h20, 1'b0, 4'd4,  8'hFF, 8'hA0},
    {4'd0,  8'h45, 8'h38, 8'h28, 1'b0, 4'd5,  8'h83, 8'h28},
    {4'd0,  8'h99, 8'h01, 8'h28, 1'b1, 4'd5,  8'h00, 8'h2B},
    {4'd0,  8'h99, 8'h01, 8'hA8, 1'b0, 4'd7,  8'h00, 8'hA9},
    {4'd1,  8'h42, 8'h13, 8'h29, 1'b1, 4'd6,  8'h29, 8'h29},
    {4'd1,  8'h10, 8'h25, 8'h69, 1'b1, 4'd6,  8'h85, 8'hE8},
    {4'd5,  8'h40, 8'h40, 8'h20, 1'b0, 4'd8,  8'h40, 8'h23},
    {4'd5,  8'h10, 8'h20, 8'h60, 1'b0, 4'd8,  8'h10, 8'hE0},
    {4'd2,  8'hF0, 8'h0F, 8'h61, 1'b0, 4'd9,  8'h00, 8'h63},
    {4'd3,  8'h80, 8'h01, 8'h20, 1'b0, 4'd9,  8'h81, 8'hA0},
    {4'd4,  8'hFF, 8'h0F, 8'h23, 1'b0, 4'd9,  8'hF0, 8'hA1},
    {4'd14, 8'h55, 8'h00, 8'hA0, 1'b0, 4'd9,  8'h00, 8'h22},
    {4'd6,  8'h00, 8'h81, 8'h20, 1'b0, 4'd10, 8'h02, 8'h21},
    {4'd7,  8'h00, 8'h01, 8'hA0, 1'b0, 4'd10, 8'h00, 8'h23},
    {4'd8,  8'h00, 8'h40, 8'h21, 1'b0, 4'd10, 8'h81, 8'hA0},
    {4'd9,  8'h00, 8'h02, 8'h21, 1'b0, 4'd10, 8'h81, 8'hA0},
    {4'd9,  8'h00, 8'h01, 8'h20, 1'b0, 4'd10, 8'h00, 8'h23},
    {4'd10, 8'h01, 8'hC0, 8'h20, 1'b0, 4'd11, 8'h01, 8'hE2},
    {4'd11, 8'h01, 8'hC0, 8'h20, 1'b0, 4'd11, 8'h01, 8'h22},
    {4'd12, 8'h0F, 8'hF0, 8'h20, 1'b0, 4'd12, 8'hFF, 8'h22},
    {4'd13, 8'h0F, 8'h3C, 8'hA1, 1'b0, 4'd12, 8'h30, 8'hA1},
    {4'd15, 8'h77, 8'h00, 8'h5D, 1'b0, 4'd13, 8'h77, 8'h7D},
    {4'd2,  8'h01, 8'h01, 8'h1C, 1'b0, 4'd13, 8'h01, 8'h3C}
  };

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; 4'd12: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got_r, exp_r,
                       input logic [7:0] got_s, exp_s);
    checks++;
    if (got_r !== exp_r || got_s !== exp_s) begin
      errors++;
      $display("FAIL %s: res=%h st=%h expected res=%h st=%h", tag, got_r, got_s, exp_r, exp_s);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", res, 8'h00, st_out, 8'h20);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {op, acc, opnd, st_in, enh} = VEC[i][48:20];
      @(negedge clk);
      check(req_name(VEC[i][19:16]), res, VEC[i][15:8], st_out, VEC[i][7:0]);
    end

    // R2: new inputs applied between edges do not reach the outputs early
    op = 4'd14; opnd = 8'h5A; st_in = 8'h20; acc = 8'h00; enh = 1'b0;
    #1;
    check("R2 hold before edge", res, 8'h01, st_out, 8'h3C);
    @(negedge clk);
    check("R2 update after edge", res, 8'h5A, st_out, 8'h20);

    // R1: reset in mid-run overrides live inputs
    op = 4'd0; acc = 8'h80; opnd = 8'h80; st_in = 8'hFF; rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", res, 8'h00, st_out, 8'h20);
    rst = 1'b0;
    // R13 with decimal flag set: shift is unaffected by D, D passes through
    op = 4'd6; opnd = 8'h01; st_in = 8'h28;
    @(negedge clk);
    check("R13 D passes through shift", res, 8'h02, st_out, 8'h28);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end
endmodule